// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block places one group of boundary cells between the core logic and the pad of each bidirectional device pin, and links every cell into one serial path from `scanIn` to `scanOut`. A test-access controller outside the block drives the capture, shift and update strobes and a 3-bit mode code. Each cell has a shift stage, clocked on the rising test-clock edge, and a separate hold latch, loaded on the falling edge. Because the two stages are separate, the block can sample live pins while the device runs normally, preload values without disturbing the pads, and later drive, clamp or tristate the pads from those values.

Each pin `k` owns three consecutive chain positions. Position `3k` observes the pad input. Position `3k+1` observes the core output data. Position `3k+2` observes the core output enable. Position 0 sits next to `scanIn`. The last position, `3*PIN_COUNT-1`, drives `scanOut`. A shift moves data one position toward `scanOut` per clock.

Top module: `bscan_chain`

## Requirements
- R1: While `trstN` is low, every shift stage and every hold latch is cleared to 0 asynchronously, so `scanOut` reads 0.
- R2: Mode codes are 0 normal, 1 sample/preload, 2 external test, 3 internal test, 4 clamp and 5 high-impedance; codes 6 and 7 behave as normal. Only modes 1, 2 and 3 select the chain; in any other mode the three strobes have no effect on the shift stages or the hold latches.
- R3: On a rising `tck` with `captureEn` high in a chain mode, position `3k` loads `padIn[k]`, position `3k+1` loads `coreOut[k]` and position `3k+2` loads `coreOe[k]`. Capture takes priority over a simultaneous shift.
- R4: On a rising `tck` with `shiftEn` high (and no capture) in a chain mode, position 0 loads `scanIn`, each other position loads its lower neighbour, and `scanOut` always shows the last position.
- R5: On a falling `tck` with `updateEn` high in a chain mode, every hold latch copies its shift stage. The hold latches keep their value through shifts and captures.
- R6: In normal, sample/preload and internal-test modes, `padOut` equals `coreOut` and `padOe` equals `coreOe`.
- R7: In external-test and clamp modes, `padOut[k]` is the hold latch at `3k+1` and `padOe[k]` is the hold latch at `3k+2`.
- R8: In high-impedance mode, every `padOe` bit is 0.
- R9: In internal-test mode, `coreIn[k]` is the hold latch at `3k`. In every other mode, `coreIn` equals `padIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Mode code (see R2) |
| captureEn | input | 1 | Capture strobe |
| shiftEn | input | 1 | Shift strobe |
| updateEn | input | 1 | Update strobe, acted on at the falling edge |
| scanIn | input | 1 | Serial data into position 0 |
| scanOut | output | 1 | Serial data from the last position |
| coreOut | input | PIN_COUNT | Output data from the core |
| coreOe | input | PIN_COUNT | Output enables from the core |
| coreIn | output | PIN_COUNT | Input data to the core |
| padIn | input | PIN_COUNT | Input data from the pads |
| padOut | output | PIN_COUNT | Output data to the pads |
| padOe | output | PIN_COUNT | Output enables to the pads |

## Verification
The bench preloads values in sample mode and confirms that the pads still follow the core; a design that lets the hold latches reach the pads too early would disturb a running device. It asserts capture and shift together to check that capture wins, and it checks that the observed bits land at the positions given above. It pulses all strobes in clamp mode and checks that the pads and `scanOut` do not move; a design that decodes strobes without regard to the mode would corrupt the clamp pattern. It also checks that a reset in the middle of external test releases the pads to high impedance.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_SAMPLE = 3'd1,
    MODE_EXTEST = 3'd2,
    MODE_INTEST = 3'd3,
    MODE_CLAMP  = 3'd4,
    MODE_HIGHZ  = 3'd5
  } scanMode_e;

  typedef struct packed {
    logic doCapture;
    logic doShift;
    logic doUpdate;
    logic padFromLatch;
    logic padsOff;
    logic coreFromLatch;
  } scanCtl_t;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       captureEn,
  input  logic       shiftEn,
  input  logic       updateEn,
  output scanCtl_t   ctl
);

  logic chainSel;

  always_comb begin
    chainSel = (mode == MODE_SAMPLE) || (mode == MODE_EXTEST) || (mode == MODE_INTEST);
    ctl.doCapture     = chainSel && captureEn;
    ctl.doShift       = chainSel && shiftEn && !captureEn;
    ctl.doUpdate      = chainSel && updateEn;
    ctl.padFromLatch  = (mode == MODE_EXTEST) || (mode == MODE_CLAMP);
    ctl.padsOff       = (mode == MODE_HIGHZ);
    ctl.coreFromLatch = (mode == MODE_INTEST);
  end

endmodule

// File: rtl/bscan_datapath.sv
module bscan_datapath
  import bscan_pkg::*;
#(
  parameter int PIN_COUNT = 4
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  scanCtl_t             ctl,
  input  logic                 scanIn,
  output logic                 scanOut,
  input  logic [PIN_COUNT-1:0] coreOut,
  input  logic [PIN_COUNT-1:0] coreOe,
  output logic [PIN_COUNT-1:0] coreIn,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe
);

  localparam int CELLS = 3 * PIN_COUNT;

  logic [CELLS-1:0] shiftStage;
  logic [CELLS-1:0] holdLatch;
  logic [CELLS-1:0] observed;
  logic [PIN_COUNT-1:0] latIn, latOut, latOe;

  for (genvar k = 0; k < PIN_COUNT; k++) begin : g_pin
    assign observed[3*k]   = padIn[k];
    assign observed[3*k+1] = coreOut[k];
    assign observed[3*k+2] = coreOe[k];
    assign latIn[k]  = holdLatch[3*k];
    assign latOut[k] = holdLatch[3*k+1];
    assign latOe[k]  = holdLatch[3*k+2];
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      shiftStage <= '0;
    end else if (ctl.doCapture) begin
      shiftStage <= observed;
    end else if (ctl.doShift) begin
      shiftStage <= {shiftStage[CELLS-2:0], scanIn};
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      holdLatch <= '0;
    end else if (ctl.doUpdate) begin
      holdLatch <= shiftStage;
    end
  end

  assign scanOut = shiftStage[CELLS-1];

  always_comb begin
    padOut = ctl.padFromLatch ? latOut : coreOut;
    padOe  = ctl.padFromLatch ? latOe  : coreOe;
    if (ctl.padsOff) padOe = '0;
    coreIn = ctl.coreFromLatch ? latIn : padIn;
  end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int PIN_COUNT = 4
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  logic [2:0]           mode,
  input  logic                 captureEn,
  input  logic                 shiftEn,
  input  logic                 updateEn,
  input  logic                 scanIn,
  output logic                 scanOut,
  input  logic [PIN_COUNT-1:0] coreOut,
  input  logic [PIN_COUNT-1:0] coreOe,
  output logic [PIN_COUNT-1:0] coreIn,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe
);

  scanCtl_t ctl;

  bscan_ctrl ctrl_i (
    .mode(mode), .captureEn(captureEn), .shiftEn(shiftEn),
    .updateEn(updateEn), .ctl(ctl)
  );

  bscan_datapath #(.PIN_COUNT(PIN_COUNT)) dp_i (
    .tck(tck), .trstN(trstN), .ctl(ctl), .scanIn(scanIn), .scanOut(scanOut),
    .coreOut(coreOut), .coreOe(coreOe), .coreIn(coreIn),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

endmodule

// File: rtl/bscan_chain_checker.sv
module bscan_chain_checker #(
  parameter int PIN_COUNT = 4
) (
  input logic                 tck,
  input logic                 trstN,
  input logic [2:0]           mode,
  input logic                 captureEn,
  input logic                 shiftEn,
  input logic                 updateEn,
  input logic                 scanOut,
  input logic [PIN_COUNT-1:0] coreOut,
  input logic [PIN_COUNT-1:0] coreOe,
  input logic [PIN_COUNT-1:0] coreIn,
  input logic [PIN_COUNT-1:0] padIn,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOe
);

  logic passMode, unselMode;
  assign passMode  = (mode == 3'd0) || (mode == 3'd1) || (mode == 3'd3) || (mode > 3'd5);
  assign unselMode = !((mode == 3'd1) || (mode == 3'd2) || (mode == 3'd3));

  assert_reset_clear_R1: assert property (@(posedge tck) !trstN |-> !scanOut);

  assert_unselected_hold_R2: assert property (@(posedge tck) disable iff (!trstN)
    (unselMode && $past(unselMode) && $past(trstN)) |-> $stable(scanOut));

  assert_core_pass_R6: assert property (@(posedge tck) disable iff (!trstN)
    passMode |-> (padOut == coreOut && padOe == coreOe));

  assert_latch_steady_R5: assert property (@(posedge tck) disable iff (!trstN)
    (mode == 3'd2 && $past(mode) == 3'd2 && $past(trstN) && !updateEn) |-> $stable(padOut) && $stable(padOe));

  assert_tristate_R8: assert property (@(posedge tck) disable iff (!trstN)
    (mode == 3'd5) |-> (padOe == '0));

  assert_core_in_R9: assert property (@(posedge tck) disable iff (!trstN)
    (mode != 3'd3) |-> (coreIn == padIn));

endmodule

bind bscan_chain bscan_chain_checker #(.PIN_COUNT(PIN_COUNT)) checker_i (
  .tck(tck), .trstN(trstN), .mode(mode), .captureEn(captureEn), .shiftEn(shiftEn),
  .updateEn(updateEn), .scanOut(scanOut), .coreOut(coreOut), .coreOe(coreOe),
  .coreIn(coreIn), .padIn(padIn), .padOut(padOut), .padOe(padOe)
);

// File: tb/bscan_chain_tb.sv
module bscan_chain_tb_top;

  localparam int PINS = 4;
  localparam int CELLS = 3 * PINS;

  logic tck = 1'b0;
  logic trstN;
  logic [2:0] mode;
  logic captureEn, shiftEn, updateEn, scanIn;
  logic scanOut;
  logic [PINS-1:0] coreOut, coreOe, coreIn, padIn, padOut, padOe;

  int total = 0;
  int bad = 0;

  always #5 tck = ~tck;

  bscan_chain #(.PIN_COUNT(PINS)) dut_i (
    .tck(tck), .trstN(trstN), .mode(mode), .captureEn(captureEn), .shiftEn(shiftEn),
    .updateEn(updateEn), .scanIn(scanIn), .scanOut(scanOut), .coreOut(coreOut),
    .coreOe(coreOe), .coreIn(coreIn), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    #2;
  endtask

  function automatic logic [CELLS-1:0] buildVec(input logic [PINS-1:0] pi, input logic [PINS-1:0] co,
                                                input logic [PINS-1:0] oe);
    logic [CELLS-1:0] v;
    for (int k = 0; k < PINS; k++) begin
      v[3*k] = pi[k];
      v[3*k+1] = co[k];
      v[3*k+2] = oe[k];
    end
    return v;
  endfunction

  task automatic shiftVec(input logic [CELLS-1:0] inV, output logic [CELLS-1:0] outV);
    for (int j = 0; j < CELLS; j++) begin
      outV[CELLS-1-j] = scanOut;
      scanIn = inV[CELLS-1-j];
      shiftEn = 1'b1;
      tick();
    end
    shiftEn = 1'b0;
  endtask

  task automatic pulseUpdate();
    updateEn = 1'b1;
    tick();
    updateEn = 1'b0;
  endtask

  task automatic pulseCapture();
    captureEn = 1'b1;
    tick();
    captureEn = 1'b0;
  endtask

  task automatic testReset();
    trstN = 1'b0; mode = 3'd0;
    coreOut = 4'hA; coreOe = 4'h6; padIn = 4'h3;
    tick(); tick();
    check(scanOut == 1'b0, "R1 scanOut in reset", {31'd0, scanOut}, 0);
    trstN = 1'b1;
    tick();
    check(padOut == coreOut && padOe == coreOe, "R6 normal pads", {padOut, padOe}, {coreOut, coreOe});
    check(coreIn == padIn, "R9 normal coreIn", coreIn, padIn);
  endtask

  task automatic testSample();
    logic [CELLS-1:0] got;
    mode = 3'd1; coreOut = 4'h5; coreOe = 4'hC; padIn = 4'h9;
    pulseCapture();
    coreOut = 4'h0; coreOe = 4'h0; padIn = 4'h0;
    shiftVec('0, got);
    check(got == buildVec(4'h9, 4'h5, 4'hC), "R3 capture positions", got, buildVec(4'h9, 4'h5, 4'hC));
    check(padOut == coreOut && padOe == coreOe, "R6 sample pads follow core", {padOut, padOe}, {coreOut, coreOe});
  endtask

  task automatic testShiftThrough();
    logic [CELLS-1:0] got;
    mode = 3'd1;
    shiftVec(12'hB3D, got);
    shiftVec(12'h000, got);
    check(got == 12'hB3D, "R4 chain length and order", got, 12'hB3D);
  endtask

  task automatic testPreloadExtest();
    logic [CELLS-1:0] got;
    logic [CELLS-1:0] v;
    mode = 3'd1; coreOut = 4'h3; coreOe = 4'hF;
    v = buildVec(4'h0, 4'hA, 4'h6);
    shiftVec(v, got);
    pulseUpdate();
    check(padOut == 4'h3 && padOe == 4'hF, "R6 preload does not reach pads", {padOut, padOe}, {4'h3, 4'hF});
    mode = 3'd2;
    tick();
    check(padOut == 4'hA && padOe == 4'h6, "R7 extest drives latches", {padOut, padOe}, {4'hA, 4'h6});
    shiftVec(buildVec(4'h0, 4'h5, 4'h9), got);
    check(padOut == 4'hA && padOe == 4'h6, "R5 latch held during shift", {padOut, padOe}, {4'hA, 4'h6});
    pulseUpdate();
    check(padOut == 4'h5 && padOe == 4'h9, "R5 update in extest", {padOut, padOe}, {4'h5, 4'h9});
  endtask

  task automatic testClamp();
    logic so;
    mode = 3'd4;
    tick();
    so = scanOut;
    check(padOut == 4'h5 && padOe == 4'h9, "R7 clamp drives latches", {padOut, padOe}, {4'h5, 4'h9});
    for (int j = 0; j < 6; j++) begin
      scanIn = ~scanIn; shiftEn = 1'b1; captureEn = j[0]; updateEn = 1'b1;
      tick();
    end
    shiftEn = 1'b0; captureEn = 1'b0; updateEn = 1'b0;
    tick();
    check(padOut == 4'h5 && padOe == 4'h9, "R2 clamp ignores strobes (pads)", {padOut, padOe}, {4'h5, 4'h9});
    check(scanOut == so, "R2 clamp ignores strobes (chain)", {31'd0, scanOut}, {31'd0, so});
  endtask

  task automatic testHighz();
    mode = 3'd5; coreOe = 4'hF; coreOut = 4'hF;
    tick();
    check(padOe == 4'h0, "R8 highz oe", padOe, 0);
    mode = 3'd7;
    tick();
    check(padOut == coreOut && padOe == coreOe, "R2 code 7 acts as normal", {padOut, padOe}, {coreOut, coreOe});
  endtask

  task automatic testIntest();
    logic [CELLS-1:0] got;
    mode = 3'd3; padIn = 4'h0; coreOut = 4'h2; coreOe = 4'h1;
    shiftVec(buildVec(4'hD, 4'h0, 4'h0), got);
    pulseUpdate();
    check(coreIn == 4'hD, "R9 intest coreIn from latch", coreIn, 4'hD);
    check(padOut == 4'h2 && padOe == 4'h1, "R6 intest pads follow core", {padOut, padOe}, {4'h2, 4'h1});
  endtask

  task automatic testPriority();
    logic [CELLS-1:0] got;
    mode = 3'd1; padIn = 4'h6; coreOut = 4'h1; coreOe = 4'h8;
    captureEn = 1'b1; shiftEn = 1'b1; scanIn = 1'b1;
    tick();
    captureEn = 1'b0; shiftEn = 1'b0;
    shiftVec('0, got);
    check(got == buildVec(4'h6, 4'h1, 4'h8), "R3 capture beats shift", got, buildVec(4'h6, 4'h1, 4'h8));
  endtask

  task automatic testResetMidExtest();
    logic [CELLS-1:0] got;
    mode = 3'd1;
    shiftVec(buildVec(4'h0, 4'hF, 4'hF), got);
    pulseUpdate();
    mode = 3'd2;
    tick();
    check(padOe == 4'hF, "R7 extest enables set", padOe, 4'hF);
    trstN = 1'b0;
    #1;
    check(padOe == 4'h0 && padOut == 4'h0 && scanOut == 1'b0, "R1 async reset clears latches",
          {padOe, padOut, 3'd0, scanOut}, 0);
    tick();
    trstN = 1'b1;
    tick();
  endtask

  initial begin
    captureEn = 0; shiftEn = 0; updateEn = 0; scanIn = 0;
    testReset();
    testSample();
    testShiftThrough();
    testPreloadExtest();
    testClamp();
    testHighz();
    testIntest();
    testPriority();
    testResetMidExtest();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule